// File: doc/BRIEF.md
# DS3 Idle and Far-End Receive Failure Alarm Monitor

This block sits behind a DS3 receive framer and turns one summary per received M-frame into two alarm states and an interrupt. With each M-frame the framer presents validity flags for the M-, F- and P-bits, the three C-bits carried in F-frame 3, the two X-bits, and a flag saying whether the payload matched the repeating 1100 idle pattern. A single-cycle `frame_done` strobe marks the cycle in which those flags are valid. All state changes happen on the clock edge that samples `frame_done`; between strobes every output holds.

The Idle alarm is integrated by an up/down counter. A frame that meets every idle condition moves the counter up by one, and any other frame moves it down by one. The counter is bounded at 0 and at 63. Idle is raised when the counter reaches 63 and dropped only when it returns to 0, so a burst of mixed traffic cannot make the alarm chatter. The far-end receive failure (yellow) alarm follows the X-bits frame by frame: it is set by a frame whose X-bits are both 0 and cleared by the first frame where they are not.

Each alarm transition sets a sticky interrupt-status bit, which is cleared by a write-one-to-clear pulse. An interrupt request is raised while any status bit is set and enabled.

Top module: `ds3_alarm_mon`

## Requirements
- R1: After reset `idle_alarm`, `ferf_alarm`, `int_status` and `irq` are all 0, and the idle counter is 0.
- R2: A frame is idle-type only when `m_ok`, `f_ok` and `p_ok` are all 1, `cbits` is 3'b000, `xbits` is 2'b11 and `pat_ok` is 1. Any other combination counts as a non-idle frame.
- R3: Each idle-type frame raises the counter by one. At 63 it saturates and does not move further.
- R4: Each non-idle frame lowers the counter by one. At 0 it stays at 0.
- R5: `idle_alarm` goes to 1 on the edge where the counter reaches 63. It goes to 0 only on the edge where the counter reaches 0, and holds its value for every count in between.
- R6: In a cycle with `frame_done` low, the counter and both alarm states keep their values, whatever the flag inputs are.
- R7: On every `frame_done`, `ferf_alarm` becomes 1 if `xbits` is 2'b00 and 0 otherwise.
- R8: `int_status[0]` is set by each change of `idle_alarm`, and `int_status[1]` by each change of `ferf_alarm`. Each bit stays set until a 1 on the matching bit of `int_clr`. If a set and a clear fall in the same cycle, the set wins.
- R9: `irq` equals the OR over i of `int_status[i] & int_en[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_done | input | 1 | One-cycle strobe: the frame summary flags are valid |
| m_ok | input | 1 | M-bits of the frame were valid |
| f_ok | input | 1 | F-bits of the frame were valid |
| p_ok | input | 1 | P-bits of the frame were valid |
| cbits | input | 3 | The three C-bits of F-frame 3 |
| xbits | input | 2 | The two X-bits of the frame |
| pat_ok | input | 1 | The payload matched the repeating 1100 pattern |
| int_en | input | 2 | Interrupt enables; bit 0 is idle, bit 1 is FERF |
| int_clr | input | 2 | Write-one-to-clear pulses for `int_status` |
| idle_alarm | output | 1 | Idle condition declared |
| ferf_alarm | output | 1 | Far-end receive failure declared |
| int_status | output | 2 | Sticky change flags; bit 0 is idle, bit 1 is FERF |
| irq | output | 1 | Interrupt request |

## Verification
Runs of exactly 62, 63 and more than 63 idle frames show where the alarm is declared and that the counter saturates. The next long run of non-idle frames must take a full 63 frames to clear the alarm, which would not be the case if the counter had kept counting above 63. Frames that fail exactly one idle condition at a time show that each flag, each C-bit and each X-bit is qualified on its own. Quiet cycles with idle-looking flags and no strobe show that the state holds between strobes. A seeded random mix, weighted towards idle frames so that the counter travels its whole range, exercises FERF toggling, clear-versus-set collisions and the enable masking.

// File: rtl/ds3_alm_pkg.sv
package ds3_alm_pkg;
    localparam int C_W     = 3;
    localparam int X_W     = 2;
    localparam int IRQ_N   = 2;
    localparam int IRQ_IDLE = 0;
    localparam int IRQ_FERF = 1;
endpackage

// File: rtl/ds3_idle_integ.sv
module ds3_idle_integ
    import ds3_alm_pkg::*;
#(
    parameter int CNT_MAX = 63
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           frame_done,
    input  logic           m_ok,
    input  logic           f_ok,
    input  logic           p_ok,
    input  logic [C_W-1:0] cbits,
    input  logic [X_W-1:0] xbits,
    input  logic           pat_ok,
    output logic           idle,
    output logic           idle_chg
);
    localparam int CNT_W = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] TOP = CNT_W'(CNT_MAX);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             idle;
    } integ_t;

    integ_t st_d, st_q;
    logic   idle_frame;

    always_comb begin
        idle_frame = m_ok && f_ok && p_ok && (cbits == '0) && (&xbits) && pat_ok;
        st_d = st_q;
        if (frame_done) begin
            if (idle_frame) begin
                if (st_q.cnt != TOP) st_d.cnt = st_q.cnt + 1'b1;
            end else begin
                if (st_q.cnt != '0) st_d.cnt = st_q.cnt - 1'b1;
            end
            if (st_d.cnt == TOP)     st_d.idle = 1'b1;
            else if (st_d.cnt == '0) st_d.idle = 1'b0;
        end
        idle_chg = st_d.idle ^ st_q.idle;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign idle = st_q.idle;

    // R3: idle frame below the top raises the count by one
    a_r3_count_up: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && idle_frame && st_q.cnt != TOP) |=> st_q.cnt == $past(st_q.cnt) + 1'b1);
    // R3: saturation
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && idle_frame && st_q.cnt == TOP) |=> st_q.cnt == TOP);
    // R4: floor at zero
    a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !idle_frame && st_q.cnt == '0) |=> st_q.cnt == '0);
    // R5: alarm agrees with the counter ends
    a_r5_top_declares: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == TOP) |-> st_q.idle);
    a_r5_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == '0) |-> !st_q.idle);
    // R6: hold between strobes
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |=> $stable(st_q));
endmodule

// File: rtl/ds3_ferf_det.sv
module ds3_ferf_det
    import ds3_alm_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           frame_done,
    input  logic [X_W-1:0] xbits,
    output logic           ferf,
    output logic           ferf_chg
);
    logic ferf_d, ferf_q;

    always_comb begin
        ferf_d = ferf_q;
        if (frame_done) ferf_d = (xbits == '0);
        ferf_chg = ferf_d ^ ferf_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ferf_q <= 1'b0;
        else        ferf_q <= ferf_d;
    end

    assign ferf = ferf_q;

    // R7: all-zero X-bits declare, anything else clears
    a_r7_set: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && xbits == '0) |=> ferf_q);
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && xbits != '0) |=> !ferf_q);
endmodule

// File: rtl/ds3_alm_irq.sv
module ds3_alm_irq
    import ds3_alm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_N-1:0] chg,
    input  logic [IRQ_N-1:0] clr,
    input  logic [IRQ_N-1:0] en,
    output logic [IRQ_N-1:0] sts,
    output logic             irq
);
    logic [IRQ_N-1:0] sts_d, sts_q;

    always_comb begin
        for (int i = 0; i < IRQ_N; i++)
            sts_d[i] = chg[i] | (sts_q[i] & ~clr[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= sts_d;
    end

    assign sts = sts_q;
    assign irq = |(sts_q & en);

    generate
        for (genvar g = 0; g < IRQ_N; g++) begin : g_chk
            // R8: a change always leaves its flag set
            a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
                chg[g] |=> sts_q[g]);
            // R8: flag is sticky without a clear
            a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
                (sts_q[g] && !clr[g]) |=> sts_q[g]);
        end
    endgenerate
endmodule

// File: rtl/ds3_alarm_mon.sv
module ds3_alarm_mon
    import ds3_alm_pkg::*;
#(
    parameter int CNT_MAX = 63
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_done,
    input  logic        m_ok,
    input  logic        f_ok,
    input  logic        p_ok,
    input  logic [2:0]  cbits,
    input  logic [1:0]  xbits,
    input  logic        pat_ok,
    input  logic [1:0]  int_en,
    input  logic [1:0]  int_clr,
    output logic        idle_alarm,
    output logic        ferf_alarm,
    output logic [1:0]  int_status,
    output logic        irq
);
    logic             idle_chg, ferf_chg;
    logic [IRQ_N-1:0] chg;

    ds3_idle_integ #(.CNT_MAX(CNT_MAX)) u_integ (
        .clk(clk), .rst_n(rst_n), .frame_done(frame_done),
        .m_ok(m_ok), .f_ok(f_ok), .p_ok(p_ok),
        .cbits(cbits), .xbits(xbits), .pat_ok(pat_ok),
        .idle(idle_alarm), .idle_chg(idle_chg)
    );

    ds3_ferf_det u_ferf (
        .clk(clk), .rst_n(rst_n), .frame_done(frame_done),
        .xbits(xbits), .ferf(ferf_alarm), .ferf_chg(ferf_chg)
    );

    always_comb begin
        chg           = '0;
        chg[IRQ_IDLE] = idle_chg;
        chg[IRQ_FERF] = ferf_chg;
    end

    ds3_alm_irq u_irq (
        .clk(clk), .rst_n(rst_n), .chg(chg), .clr(int_clr),
        .en(int_en), .sts(int_status), .irq(irq)
    );

    // R9: a set and enabled flag always requests
    a_r9_irq: assert property (@(posedge clk) disable iff (!rst_n)
        ((int_status & int_en) != '0) |-> irq);
    // R1: nothing pending right after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (int_status == '0) || $past(rst_n == 1'b0) == 1'b0 || !$rose(rst_n));
endmodule

// File: tb/sim_ds3_alarm_mon.sv
module sim_ds3_alarm_mon;
    localparam int CLK_PERIOD = 10;
    localparam int MAXC = 63;

    logic clk = 0, rst_n = 0;
    logic frame_done = 0, m_ok = 0, f_ok = 0, p_ok = 0, pat_ok = 0;
    logic [2:0] cbits = 0;
    logic [1:0] xbits = 0, int_en = 0, int_clr = 0;
    logic idle_alarm, ferf_alarm, irq;
    logic [1:0] int_status;

    int checks = 0, fails = 0;
    int m_cnt = 0;
    logic m_idle = 0, m_ferf = 0;
    logic [1:0] m_ists = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ds3_alarm_mon u0 (.*);

    function automatic bit is_idle(logic m, logic f, logic p, logic [2:0] c, logic [1:0] x, logic pat);
        return m && f && p && c == 3'b000 && x == 2'b11 && pat;
    endfunction

    function automatic logic calc_irq(logic [1:0] s, logic [1:0] e);
        return |(s & e);
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(string tag, logic fd, logic m, logic f, logic p,
                        logic [2:0] c, logic [1:0] x, logic pat, logic [1:0] clr);
        logic ni, nf;
        logic [1:0] ch;
        @(negedge clk);
        frame_done = fd; m_ok = m; f_ok = f; p_ok = p;
        cbits = c; xbits = x; pat_ok = pat; int_clr = clr;
        ni = m_idle; nf = m_ferf;
        if (fd) begin
            if (is_idle(m, f, p, c, x, pat)) begin
                if (m_cnt < MAXC) m_cnt++;
            end else if (m_cnt > 0) m_cnt--;
            if (m_cnt == MAXC) ni = 1;
            else if (m_cnt == 0) ni = 0;
            nf = (x == 2'b00);
        end
        ch = {nf ^ m_ferf, ni ^ m_idle};
        m_ists = ch | (m_ists & ~clr);
        m_idle = ni; m_ferf = nf;
        @(posedge clk); #1;
        chk(tag, idle_alarm, m_idle);
        chk("R7", ferf_alarm, m_ferf);
        chk("R8", int_status, m_ists);
        chk("R9", irq, calc_irq(m_ists, int_en));
        frame_done = 0; int_clr = 0;
    endtask

    task automatic idle_frm(string tag, int n);
        for (int i = 0; i < n; i++) step(tag, 1, 1, 1, 1, 3'b000, 2'b11, 1, 2'b00);
    endtask

    task automatic busy_frm(string tag, int n);
        for (int i = 0; i < n; i++) step(tag, 1, 1, 1, 1, 3'b000, 2'b11, 0, 2'b00);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7245));
        int_en = 2'b11;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1", idle_alarm, 0); chk("R1", ferf_alarm, 0);
        chk("R1", int_status, 0); chk("R1", irq, 0);
        @(negedge clk); rst_n = 1;
        // R4 floor at zero before any idle frame, then R3/R5 climb
        busy_frm("R4", 3);
        idle_frm("R3", 62);
        chk("R5", idle_alarm, 0);
        idle_frm("R5", 1);
        chk("R5", idle_alarm, 1);
        idle_frm("R3", 10);                // saturated at 63
        step("R8", 0, 0, 0, 0, 0, 2'b11, 0, 2'b01);
        // R6: strobe absent, idle-looking and busy flags ignored
        for (int i = 0; i < 5; i++) step("R6", 0, 1, 1, 1, 0, 2'b00, 0, 2'b00);
        // R2: each single condition failing is non-idle
        step("R2", 1, 0, 1, 1, 3'b000, 2'b11, 1, 2'b00);
        step("R2", 1, 1, 0, 1, 3'b000, 2'b11, 1, 2'b00);
        step("R2", 1, 1, 1, 0, 3'b000, 2'b11, 1, 2'b00);
        step("R2", 1, 1, 1, 1, 3'b001, 2'b11, 1, 2'b00);
        step("R2", 1, 1, 1, 1, 3'b010, 2'b11, 1, 2'b00);
        step("R2", 1, 1, 1, 1, 3'b100, 2'b11, 1, 2'b00);
        step("R2", 1, 1, 1, 1, 3'b000, 2'b10, 1, 2'b00);
        step("R2", 1, 1, 1, 1, 3'b000, 2'b01, 1, 2'b00);
        chk("R2", m_cnt, 55);
        // R5 hysteresis: alarm holds down to 1, drops at 0
        busy_frm("R5", 54);
        chk("R5", idle_alarm, 1);
        busy_frm("R5", 1);
        chk("R5", idle_alarm, 0);
        // R7 FERF set/clear; R8 clear and set-wins collision
        step("R7", 1, 1, 1, 1, 0, 2'b00, 0, 2'b11);
        step("R7", 1, 1, 1, 1, 0, 2'b00, 0, 2'b00);
        step("R8", 1, 1, 1, 1, 0, 2'b01, 0, 2'b10);
        int_en = 2'b01;
        step("R9", 0, 0, 0, 0, 0, 0, 0, 2'b01);
        int_en = 2'b10;
        step("R9", 0, 0, 0, 0, 0, 0, 0, 2'b00);
        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r = $urandom;
            int_en = r[1:0];
            if (r[31:28] < 11)
                step("R3", r[2] | r[3], 1, 1, 1, 0, 2'b11, 1, r[5:4]);
            else
                step("R4", r[2] | r[3], r[6] | r[14], r[7] | r[15], r[8] | r[16],
                     r[11:9] & r[19:17], r[13:12], r[20] | r[21], r[5:4]);
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule